// File: doc/BRIEF.md
# Parallel CRC Link Checker

This block protects a 32-bit on-chip link with a cyclic redundancy check computed in a single cycle. On the sending side it takes a data word qualified by a valid strobe. It appends a check field and presents a registered, systematic codeword: the message sits in the upper field and the check bits in the lower field. On the receiving side it recomputes the check field from the received message field and compares it with the received check field. It then presents the message field together with a registered mismatch flag.

A mismatch is only a request to send the word again. The block never alters received data, so the retransmit machinery beside it decides what to do with a flagged word. The `CRC_W` parameter selects the check width. A width of 4 gives a 36-line codeword, and a width of 8 gives a 40-line codeword for stronger protection of adjacent lines. Both generator polynomials contain the factor x+1, so every error of odd weight leaves a nonzero remainder.

Top module: `crc_link_checker`

## Requirements
- R1: One cycle after `tx_valid_i`, `tx_code_o` holds the data word in bits [CW-1:CRC_W] and, in bits [CRC_W-1:0], the remainder of data·x^CRC_W divided by the generator: x^4+x^2+x+1 when CRC_W is 4, and x^8+x^2+x+1 when CRC_W is 8.
- R2: `tx_code_valid_o` is high in exactly the cycle after each cycle with `tx_valid_i` high, and is low otherwise.
- R3: For each received codeword whose check field matches its message field, `rx_valid_o` is high in the next cycle with `rx_err_o` low and `rx_data_o` equal to the message field.
- R4: Every single-line error anywhere in the received codeword sets `rx_err_o`.
- R5: Every error burst confined to adjacent lines, with a span of at most CRC_W lines, sets `rx_err_o`.
- R6: Every error pattern of odd weight sets `rx_err_o`.
- R7: No correction is made: `rx_data_o` always equals the received message field, including when `rx_err_o` is set.
- R8: While `rst` is high, both valid outputs and `rx_err_o` are low from the following cycle onwards.
- R9: `rx_err_o` is never high unless `rx_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data_i | input | DATA_W | Word to encode |
| tx_valid_i | input | 1 | Qualifies `tx_data_i` |
| tx_code_o | output | DATA_W+CRC_W | Registered codeword {data, check} |
| tx_code_valid_o | output | 1 | Qualifies `tx_code_o` |
| rx_code_i | input | DATA_W+CRC_W | Codeword received from the link |
| rx_valid_i | input | 1 | Qualifies `rx_code_i` |
| rx_data_o | output | DATA_W | Registered message field |
| rx_valid_o | output | 1 | Qualifies `rx_data_o` and `rx_err_o` |
| rx_err_o | output | 1 | Check mismatch; request retransmission |

## Verification
The hardest conditions to reach are the ones where a burst spans the boundary between the message field and the check field, and where a burst of maximum span has random interior lines. Random traffic rarely produces such patterns. The stimulus therefore sweeps every burst span from one line up to the check width across every start line of both codeword widths. Each burst has both end lines forced to one and random interior lines. The sweep is then followed by random odd-weight patterns.

// File: rtl/crc_link_pkg.sv
package crc_link_pkg;

  localparam int LINK_DATA_W = 32;

  // Low-order generator taps (leading term implied) for supported widths.
  function automatic logic [7:0] crc_taps(input int width);
    case (width)
      4:       crc_taps = 8'h07;  // x^4 + x^2 + x + 1
      8:       crc_taps = 8'h07;  // x^8 + x^2 + x + 1
      default: crc_taps = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/crc_remainder.sv
// Unrolled parallel remainder: DATA_W shift steps from a zero seed, MSB first.
module crc_remainder #(
  parameter int                 DATA_W = 32,
  parameter int                 CRC_W  = 8,
  parameter logic [CRC_W-1:0]   TAPS   = '0
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  rem_o
);

  logic [CRC_W-1:0] stage [0:DATA_W];
  logic [DATA_W-1:0] fb;

  assign stage[0] = '0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_step
    assign fb[i]       = data_i[DATA_W-1-i] ^ stage[i][CRC_W-1];
    assign stage[i+1]  = {stage[i][CRC_W-2:0], 1'b0} ^ (TAPS & {CRC_W{fb[i]}});
  end

  assign rem_o = stage[DATA_W];

endmodule

// File: rtl/crc_link_enc.sv
module crc_link_enc #(
  parameter int               DATA_W = 32,
  parameter int               CRC_W  = 8,
  parameter logic [CRC_W-1:0] TAPS   = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DATA_W-1:0]        data_i,
  input  logic                     valid_i,
  output logic [DATA_W+CRC_W-1:0]  code_o,
  output logic                     valid_o
);

  logic [CRC_W-1:0] check;

  crc_remainder #(.DATA_W(DATA_W), .CRC_W(CRC_W), .TAPS(TAPS)) u_rem (
    .data_i (data_i),
    .rem_o  (check)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) code_o <= {data_i, check};
    end
  end

endmodule

// File: rtl/crc_link_chk.sv
module crc_link_chk #(
  parameter int               DATA_W = 32,
  parameter int               CRC_W  = 8,
  parameter logic [CRC_W-1:0] TAPS   = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DATA_W+CRC_W-1:0]  code_i,
  input  logic                     valid_i,
  output logic [DATA_W-1:0]        data_o,
  output logic                     valid_o,
  output logic                     err_o
);

  localparam int CW = DATA_W + CRC_W;

  logic [DATA_W-1:0] msg;
  logic [CRC_W-1:0]  rx_check;
  logic [CRC_W-1:0]  recomputed;
  logic              mismatch;

  assign msg      = code_i[CW-1:CRC_W];
  assign rx_check = code_i[CRC_W-1:0];

  crc_remainder #(.DATA_W(DATA_W), .CRC_W(CRC_W), .TAPS(TAPS)) u_rem (
    .data_i (msg),
    .rem_o  (recomputed)
  );

  assign mismatch = |(recomputed ^ rx_check);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      err_o   <= valid_i & mismatch;
      if (valid_i) data_o <= msg;
    end
  end

endmodule

// File: rtl/crc_link_checker.sv
module crc_link_checker #(
  parameter int DATA_W = crc_link_pkg::LINK_DATA_W,
  parameter int CRC_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DATA_W-1:0]        tx_data_i,
  input  logic                     tx_valid_i,
  output logic [DATA_W+CRC_W-1:0]  tx_code_o,
  output logic                     tx_code_valid_o,
  input  logic [DATA_W+CRC_W-1:0]  rx_code_i,
  input  logic                     rx_valid_i,
  output logic [DATA_W-1:0]        rx_data_o,
  output logic                     rx_valid_o,
  output logic                     rx_err_o
);

  localparam logic [7:0]       TAPS_ALL = crc_link_pkg::crc_taps(CRC_W);
  localparam logic [CRC_W-1:0] TAPS     = TAPS_ALL[CRC_W-1:0];

  crc_link_enc #(.DATA_W(DATA_W), .CRC_W(CRC_W), .TAPS(TAPS)) u_enc (
    .clk     (clk),
    .rst     (rst),
    .data_i  (tx_data_i),
    .valid_i (tx_valid_i),
    .code_o  (tx_code_o),
    .valid_o (tx_code_valid_o)
  );

  crc_link_chk #(.DATA_W(DATA_W), .CRC_W(CRC_W), .TAPS(TAPS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .code_i  (rx_code_i),
    .valid_i (rx_valid_i),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o),
    .err_o   (rx_err_o)
  );

endmodule

// File: rtl/crc_link_checker_sva.sv
module crc_link_checker_sva #(
  parameter int DATA_W = 32,
  parameter int CRC_W  = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [DATA_W-1:0]        tx_data_i,
  input logic                     tx_valid_i,
  input logic [DATA_W+CRC_W-1:0]  tx_code_o,
  input logic                     tx_code_valid_o,
  input logic [DATA_W+CRC_W-1:0]  rx_code_i,
  input logic                     rx_valid_i,
  input logic [DATA_W-1:0]        rx_data_o,
  input logic                     rx_valid_o,
  input logic                     rx_err_o
);

  localparam int CW = DATA_W + CRC_W;

  AST_TX_MSG_FIELD: assert property (@(posedge clk) disable iff (rst)
    tx_valid_i |=> tx_code_o[CW-1:CRC_W] == $past(tx_data_i)); // R1

  AST_TX_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    tx_valid_i |=> tx_code_valid_o); // R2

  AST_TX_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tx_valid_i |=> !tx_code_valid_o); // R2

  AST_RX_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rx_valid_i |=> rx_valid_o); // R3

  AST_NO_CORRECTION: assert property (@(posedge clk) disable iff (rst)
    rx_valid_i |=> rx_data_o == $past(rx_code_i[CW-1:CRC_W])); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!tx_code_valid_o && !rx_valid_o && !rx_err_o)); // R8

  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    rx_err_o |-> rx_valid_o); // R9

endmodule

bind crc_link_checker crc_link_checker_sva #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_sva (
  .clk             (clk),
  .rst             (rst),
  .tx_data_i       (tx_data_i),
  .tx_valid_i      (tx_valid_i),
  .tx_code_o       (tx_code_o),
  .tx_code_valid_o (tx_code_valid_o),
  .rx_code_i       (rx_code_i),
  .rx_valid_i      (rx_valid_i),
  .rx_data_o       (rx_data_o),
  .rx_valid_o      (rx_valid_o),
  .rx_err_o        (rx_err_o)
);

// File: tb/crc_link_checker_bench.sv
module crc_link_checker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW  = 32;
  localparam int CW8 = DW + 8;
  localparam int CW4 = DW + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [DW-1:0]  tx_data  = '0;
  logic           tx_valid = 1'b0;
  logic           rx_valid = 1'b0;
  logic [CW8-1:0] rxc8 = '0, code8;
  logic [CW4-1:0] rxc4 = '0, code4;
  logic           cv8, cv4, v8, v4, e8, e4;
  logic [DW-1:0]  d8, d4;

  crc_link_checker #(.DATA_W(DW), .CRC_W(8)) u_crc_link_checker (
    .clk(clk), .rst(rst), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_code_o(code8), .tx_code_valid_o(cv8), .rx_code_i(rxc8),
    .rx_valid_i(rx_valid), .rx_data_o(d8), .rx_valid_o(v8), .rx_err_o(e8));

  crc_link_checker #(.DATA_W(DW), .CRC_W(4)) u_crc_link_checker_w4 (
    .clk(clk), .rst(rst), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_code_o(code4), .tx_code_valid_o(cv4), .rx_code_i(rxc4),
    .rx_valid_i(rx_valid), .rx_data_o(d4), .rx_valid_o(v4), .rx_err_o(e4));

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [CW8-1:0] q_tx8[$];
  logic [CW4-1:0] q_tx4[$];
  logic [DW:0]    q_rx8[$];
  logic [DW:0]    q_rx4[$];
  string          q_tag8[$];
  string          q_tag4[$];

  // Polynomial long division, independent of the unrolled shift network.
  function automatic logic [7:0] ref_rem(input logic [DW-1:0] d, input int w);
    logic [CW8-1:0] v;
    logic [CW8-1:0] g;
    v = {8'b0, d} << w;
    g = (w == 8) ? 40'h107 : 40'h17;
    for (int i = DW - 1 + w; i >= w; i--)
      if (v[i]) v = v ^ (g << (i - w));
    return v[7:0];
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [DW-1:0] d, input logic [CW8-1:0] m8,
                      input logic [CW4-1:0] m4, input string tag);
    logic [7:0]     r8;
    logic [7:0]     r4;
    logic [CW8-1:0] c8;
    logic [CW4-1:0] c4;
    r8 = ref_rem(d, 8);
    r4 = ref_rem(d, 4);
    c8 = {d, r8};
    c4 = {d, r4[3:0]};
    @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    rxc8     = c8 ^ m8;
    rxc4     = c4 ^ m4;
    rx_valid = 1'b1;
    q_tx8.push_back(c8);
    q_tx4.push_back(c4);
    q_rx8.push_back({rxc8[CW8-1:8], m8 != '0});
    q_rx4.push_back({rxc4[CW4-1:4], m4 != '0});
    q_tag8.push_back(tag);
    q_tag4.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_valid = 1'b0;
      rx_valid = 1'b0;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (cv8) begin
        if (q_tx8.size() == 0) check("R2 spurious tx valid w8", 64'd1, 64'd0);
        else check("R1 tx codeword w8", {24'b0, code8}, {24'b0, q_tx8.pop_front()});
      end
      if (cv4) begin
        if (q_tx4.size() == 0) check("R2 spurious tx valid w4", 64'd1, 64'd0);
        else check("R1 tx codeword w4", {28'b0, code4}, {28'b0, q_tx4.pop_front()});
      end
      if (v8) begin
        if (q_rx8.size() == 0) check("R3 spurious rx valid w8", 64'd1, 64'd0);
        else check({q_tag8.pop_front(), " R7 rx data/err w8"}, {31'b0, d8, e8},
                   {31'b0, q_rx8.pop_front()});
      end else if (e8) check("R9 err without valid w8", 64'd1, 64'd0);
      if (v4) begin
        if (q_rx4.size() == 0) check("R3 spurious rx valid w4", 64'd1, 64'd0);
        else check({q_tag4.pop_front(), " R7 rx data/err w4"}, {31'b0, d4, e4},
                   {31'b0, q_rx4.pop_front()});
      end else if (e4) check("R9 err without valid w4", 64'd1, 64'd0);
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [CW8-1:0] m8;
    logic [CW4-1:0] m4;
    repeat (3) @(negedge clk);
    check("R8 reset tx valid", {63'b0, cv8 | cv4}, 64'd0);
    check("R8 reset rx valid", {63'b0, v8 | v4}, 64'd0);
    check("R8 reset err",      {63'b0, e8 | e4}, 64'd0);
    rst = 1'b0;

    // R1 R3: clean words of distinct patterns
    send(32'h0000_0000, '0, '0, "R3 clean zero");
    send(32'hFFFF_FFFF, '0, '0, "R3 clean ones");
    send(32'h0000_0001, '0, '0, "R3 clean lsb");
    send(32'h8000_0000, '0, '0, "R3 clean msb");
    for (int i = 0; i < 10; i++) send($urandom, '0, '0, "R3 clean random");
    idle(3);  // R2: no valid while idle

    // R4 R5: every burst span and start line, 8-bit check
    for (int len = 1; len <= 8; len++)
      for (int s = 0; s + len <= CW8; s++) begin
        m8 = '0;
        m8[s] = 1'b1;
        m8[s+len-1] = 1'b1;
        for (int k = s + 1; k < s + len - 1; k++) m8[k] = 1'($urandom);
        send($urandom, m8, '0, (len == 1) ? "R4 single w8" : "R5 burst w8");
      end

    // R4 R5: every burst span and start line, 4-bit check
    for (int len = 1; len <= 4; len++)
      for (int s = 0; s + len <= CW4; s++) begin
        m4 = '0;
        m4[s] = 1'b1;
        m4[s+len-1] = 1'b1;
        for (int k = s + 1; k < s + len - 1; k++) m4[k] = 1'($urandom);
        send($urandom, '0, m4, (len == 1) ? "R4 single w4" : "R5 burst w4");
      end

    // R6: random odd-weight patterns
    for (int i = 0; i < 40; i++) begin
      m8 = {8'($urandom), 32'($urandom)};
      if ($countones(m8) % 2 == 0) m8[0] = ~m8[0];
      m4 = {4'($urandom), 32'($urandom)};
      if ($countones(m4) % 2 == 0) m4[0] = ~m4[0];
      send($urandom, m8, m4, "R6 odd weight");
    end

    // R7: errors only in message field, data passed uncorrected
    for (int i = 0; i < 8; i++) begin
      m8 = '0;
      m4 = '0;
      m8[8 + ($urandom % DW)] = 1'b1;
      m4[4 + ($urandom % DW)] = 1'b1;
      send($urandom, m8, m4, "R7 uncorrected");
    end

    idle(5);
    check("R3 all words returned w8", 64'(q_rx8.size() + q_tx8.size()), 64'd0);
    check("R3 all words returned w4", 64'(q_rx4.size() + q_tx4.size()), 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule